// File: doc/BRIEF.md
# Command-Driven I2C Controller Byte Engine

This block moves an I2C bus one byte at a time under control of a small set of command bits. The host loads the byte to send into the low half of a buffer register and then sets command bits for a START condition, a byte transmit, a byte receive (optionally marked as the final byte) and a STOP condition. Several bits can be set in one write. The engine always runs them in the order START, transmit, receive, STOP, and each bit clears itself when its bus phase is finished. A received byte is returned in the upper half of the buffer register.

Results are reported through six sticky event flags that the host clears by writing ones. An interrupt enable register uses the same bit positions, and the interrupt line is raised while any enabled flag is set. If the engine loses arbitration, or is told to move data while it does not hold the bus, it drops every pending command, releases both lines and goes idle. Bus timing comes from an external `tick` strobe. Each bus bit takes four ticks, one per quarter period. Both bus lines are open drain, so the outputs are pull-down enables.

The register writes are plain single-cycle strobes. There is no streaming data path, so no back-pressure rules apply.

Top module: `i2ceng_top`

## Requirements
- R1: After reset the pending command bits, event flags and interrupt enables are all zero, the interrupt line is low and neither bus line is pulled low.
- R2: Command bits are START=bit 0, TX=bit 1, RX=bit 3, RX-last=bit 4 and STOP=bit 5 (bit 2 is ignored). Bits set together run as START, then TX, then RX, then STOP. Each bit clears itself when its phase ends, and a finished START leaves both lines held low.
- R3: TX shifts out the byte held in buffer bits 7:0, MSB first, and then samples the ninth bit. A low ninth bit sets event bit 0 (ACK), and a high one sets event bit 1 (NACK). The low buffer byte reads back unchanged.
- R4: RX shifts in eight bits MSB first, places the byte in buffer bits 15:8 and sets event bit 2. Without RX-last the engine pulls SDA low on the ninth bit (ACK).
- R5: When RX-last is set with RX, the engine leaves SDA released on the ninth bit (NACK). RX-last clears together with RX.
- R6: STOP ends with both lines released, sets event bit 4 and gives up bus ownership.
- R7: If the engine reads SDA low while it is sending a 1 during a transmit data bit, it sets event bit 3 (arbitration loss), clears all pending commands and releases both lines.
- R8: A TX or RX command issued while the engine does not own the bus (no START since the last STOP or error) sets event bit 5 (abnormal) and clears all pending commands.
- R9: Writing 1 to an event bit clears it and writing 0 leaves it unchanged. A new event wins over a clear of the same bit in the same cycle.
- R10: `irq` is high exactly when some event bit and the enable bit at the same position are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Quarter-bit timing strobe |
| cmd_we | input | 1 | Command write strobe, ORs bits into the pending set |
| cmd_wdata | input | 6 | Command bits |
| buf_we | input | 1 | Transmit byte write strobe |
| buf_wdata | input | BYTE_W | Byte to transmit |
| sts_we | input | 1 | Event clear strobe |
| sts_wdata | input | 6 | Ones clear the matching event bits |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 6 | Interrupt enable value |
| sda_i | input | 1 | Sampled SDA bus level |
| cmd_pend | output | 6 | Pending command bits |
| buf_rdata | output | 2*BYTE_W | {received byte, transmit byte} |
| status | output | 6 | Sticky event flags |
| ien | output | 6 | Interrupt enables |
| irq | output | 1 | Interrupt request |
| scl_low | output | 1 | Pull SCL low |
| sda_low | output | 1 | Pull SDA low |

## Verification
Two things can happen in the same cycle. The engine can raise an event flag while the host writes a clear to that flag. The engine can also clear or flush pending command bits in the cycle that a host command write ORs new ones in. The bench clears flags between transactions, clears one flag out of several, and reads back the remaining set. The checker requires every raised event to be visible in the next cycle whatever clear was written, and requires the pending set to be empty after a flush unless a command write landed on that edge. Arbitration loss is provoked by a bus model that pulls SDA low during a bit the engine sends as 1, and the bench then checks the empty pending set and the released lines.

// File: rtl/i2ceng_pkg.sv
package i2ceng_pkg;
  localparam int NBITS = 6;
  localparam int C_START = 0;
  localparam int C_TX    = 1;
  localparam int C_RX    = 3;
  localparam int C_LAST  = 4;
  localparam int C_STOP  = 5;
  localparam logic [NBITS-1:0] CMD_MASK = 6'b111011;

  localparam int E_ACK = 0;
  localparam int E_NAK = 1;
  localparam int E_RXD = 2;
  localparam int E_ARB = 3;
  localparam int E_STP = 4;
  localparam int E_ABN = 5;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_TX, ST_RX, ST_STOP} eng_state_e;
endpackage

// File: rtl/i2ceng_irq.sv
module i2ceng_irq
  import i2ceng_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] evt,
  input  logic             sts_we,
  input  logic [NBITS-1:0] sts_wdata,
  input  logic             ien_we,
  input  logic [NBITS-1:0] ien_wdata,
  output logic [NBITS-1:0] status,
  output logic [NBITS-1:0] ien,
  output logic             irq
);
  logic [NBITS-1:0] hit;

  for (genvar i = 0; i < NBITS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        status[i] <= 1'b0;
        ien[i]    <= 1'b0;
      end else begin
        if (evt[i])                        status[i] <= 1'b1;
        else if (sts_we && sts_wdata[i])   status[i] <= 1'b0;
        if (ien_we)                        ien[i]    <= ien_wdata[i];
      end
    end
    assign hit[i] = status[i] & ien[i];
  end

  assign irq = |hit;
endmodule

// File: rtl/i2ceng_seq.sv
module i2ceng_seq
  import i2ceng_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_we,
  input  logic [NBITS-1:0]  cmd_wdata,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              sda_i,
  output logic [NBITS-1:0]  cmd_pend,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [NBITS-1:0]  evt,
  output logic              scl_low,
  output logic              sda_low
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  eng_state_e        state, state_n;
  logic [1:0]        q, q_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n, rx_n;
  logic              own, own_n, ack_r, ack_n;
  logic              scl_n, sda_n, flush;
  logic [NBITS-1:0]  clr, evt_n, pend_n;

  always_comb begin
    state_n = state;  q_n = q;  cnt_n = cnt;  sh_n = sh;  rx_n = rx_byte;
    own_n = own;  ack_n = ack_r;  scl_n = scl_low;  sda_n = sda_low;
    evt_n = '0;  clr = '0;  flush = 1'b0;
    unique case (state)
      ST_IDLE: begin
        q_n = 2'd0;  cnt_n = '0;
        if (cmd_pend[C_START]) state_n = ST_START;
        else if (cmd_pend[C_TX]) begin
          if (!own) begin evt_n[E_ABN] = 1'b1; flush = 1'b1; end
          else begin state_n = ST_TX; sh_n = tx_byte; end
        end else if (cmd_pend[C_RX]) begin
          if (!own) begin evt_n[E_ABN] = 1'b1; flush = 1'b1; end
          else begin state_n = ST_RX; sh_n = '0; end
        end else if (cmd_pend[C_STOP]) state_n = ST_STOP;
      end
      ST_START: if (tick) begin
        q_n = q + 2'd1;
        unique case (q)
          2'd0: sda_n = 1'b0;
          2'd1: scl_n = 1'b0;
          2'd2: sda_n = 1'b1;
          default: begin
            scl_n = 1'b1;  own_n = 1'b1;
            clr[C_START] = 1'b1;  state_n = ST_IDLE;
          end
        endcase
      end
      ST_STOP: if (tick) begin
        q_n = q + 2'd1;
        unique case (q)
          2'd0: sda_n = 1'b1;
          2'd1: scl_n = 1'b0;
          2'd2: sda_n = 1'b0;
          default: begin
            own_n = 1'b0;  clr[C_STOP] = 1'b1;
            evt_n[E_STP] = 1'b1;  state_n = ST_IDLE;
          end
        endcase
      end
      ST_TX: if (tick) begin
        q_n = q + 2'd1;
        unique case (q)
          2'd0: sda_n = (cnt < LAST_BIT) ? ~sh[BYTE_W-1] : 1'b0;
          2'd1: scl_n = 1'b0;
          2'd2: begin
            if (cnt < LAST_BIT) begin
              if (sh[BYTE_W-1] && !sda_i) begin
                evt_n[E_ARB] = 1'b1;  flush = 1'b1;  own_n = 1'b0;
                scl_n = 1'b0;  sda_n = 1'b0;  state_n = ST_IDLE;
              end else sh_n = {sh[BYTE_W-2:0], 1'b0};
            end else ack_n = sda_i;
          end
          default: begin
            scl_n = 1'b1;
            if (cnt == LAST_BIT) begin
              evt_n[E_ACK] = !ack_r;  evt_n[E_NAK] = ack_r;
              clr[C_TX] = 1'b1;  state_n = ST_IDLE;
            end else cnt_n = cnt + 1'b1;
          end
        endcase
      end
      ST_RX: if (tick) begin
        q_n = q + 2'd1;
        unique case (q)
          2'd0: sda_n = (cnt < LAST_BIT) ? 1'b0 : !cmd_pend[C_LAST];
          2'd1: scl_n = 1'b0;
          2'd2: if (cnt < LAST_BIT) sh_n = {sh[BYTE_W-2:0], sda_i};
          default: begin
            scl_n = 1'b1;
            if (cnt == LAST_BIT) begin
              rx_n = sh;  evt_n[E_RXD] = 1'b1;
              clr[C_RX] = 1'b1;  clr[C_LAST] = 1'b1;  state_n = ST_IDLE;
            end else cnt_n = cnt + 1'b1;
          end
        endcase
      end
      default: state_n = ST_IDLE;
    endcase
    pend_n = (flush ? '0 : (cmd_pend & ~clr)) | (cmd_we ? (cmd_wdata & CMD_MASK) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;  q <= 2'd0;  cnt <= '0;  sh <= '0;  rx_byte <= '0;
      own <= 1'b0;  ack_r <= 1'b0;  scl_low <= 1'b0;  sda_low <= 1'b0;
      evt <= '0;  cmd_pend <= '0;
    end else begin
      state <= state_n;  q <= q_n;  cnt <= cnt_n;  sh <= sh_n;  rx_byte <= rx_n;
      own <= own_n;  ack_r <= ack_n;  scl_low <= scl_n;  sda_low <= sda_n;
      evt <= evt_n;  cmd_pend <= pend_n;
    end
  end
endmodule

// File: rtl/i2ceng_top.sv
module i2ceng_top
  import i2ceng_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                cmd_we,
  input  logic [5:0]          cmd_wdata,
  input  logic                buf_we,
  input  logic [BYTE_W-1:0]   buf_wdata,
  input  logic                sts_we,
  input  logic [5:0]          sts_wdata,
  input  logic                ien_we,
  input  logic [5:0]          ien_wdata,
  input  logic                sda_i,
  output logic [5:0]          cmd_pend,
  output logic [2*BYTE_W-1:0] buf_rdata,
  output logic [5:0]          status,
  output logic [5:0]          ien,
  output logic                irq,
  output logic                scl_low,
  output logic                sda_low
);
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic [NBITS-1:0]  evt;

  always_ff @(posedge clk) begin
    if (!rst_n)      tx_byte <= '0;
    else if (buf_we) tx_byte <= buf_wdata;
  end

  assign buf_rdata = {rx_byte, tx_byte};

  i2ceng_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .tx_byte(tx_byte), .sda_i(sda_i), .cmd_pend(cmd_pend), .rx_byte(rx_byte),
    .evt(evt), .scl_low(scl_low), .sda_low(sda_low)
  );

  i2ceng_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sts_we(sts_we), .sts_wdata(sts_wdata),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .status(status), .ien(ien), .irq(irq)
  );
endmodule

// File: rtl/i2ceng_chk.sv
module i2ceng_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] evt,
  input logic [5:0] cmd_pend,
  input logic [5:0] status,
  input logic       cmd_we,
  input logic       irq,
  input logic       scl_low,
  input logic       sda_low
);
  // R7: arbitration loss leaves nothing pending
  a_r7_arb_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[3] && !$past(cmd_we)) |-> (cmd_pend == 6'd0));

  // R8: abnormal command leaves nothing pending
  a_r8_abn_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[5] && !$past(cmd_we)) |-> (cmd_pend == 6'd0));

  // R6: STOP completes with both lines released
  a_r6_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    evt[4] |-> (!scl_low && !sda_low));

  // R9: every event lands in the flags, whatever clear was written
  a_r9_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != 6'd0) |=> ((status & $past(evt)) == $past(evt)));

  // R3: ACK and NACK never reported together
  a_r3_ack_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt[1:0]));

  // R10: no flag, no interrupt
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 6'd0) |-> !irq);
endmodule

bind i2ceng_top i2ceng_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .cmd_pend(cmd_pend), .status(status),
  .cmd_we(cmd_we), .irq(irq), .scl_low(scl_low), .sda_low(sda_low)
);

// File: tb/i2ceng_top_test.sv
`timescale 1ns/1ps
module i2ceng_top_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic cmd_we = 1'b0, buf_we = 1'b0, sts_we = 1'b0, ien_we = 1'b0;
  logic [5:0] cmd_wdata = '0, sts_wdata = '0, ien_wdata = '0;
  logic [7:0] buf_wdata = '0;
  logic sda_i;
  logic [5:0] cmd_pend, status, ien;
  logic [15:0] buf_rdata;
  logic irq, scl_low, sda_low;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2ceng_top uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .buf_we(buf_we), .buf_wdata(buf_wdata), .sts_we(sts_we), .sts_wdata(sts_wdata),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .sda_i(sda_i), .cmd_pend(cmd_pend),
    .buf_rdata(buf_rdata), .status(status), .ien(ien), .irq(irq),
    .scl_low(scl_low), .sda_low(sda_low)
  );

  // bus target model
  logic tdrv = 1'b0, model_rst = 1'b0;
  logic [8:0] pat [4];
  logic [7:0] seen [4];
  logic ack_seen [4];
  int bitpos = -1, bidx = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  wire scl_line = ~scl_low;
  assign sda_i = ~(sda_low | tdrv);

  initial begin
    for (int i = 0; i < 4; i++) begin pat[i] = '0; seen[i] = '0; ack_seen[i] = 1'b0; end
    forever begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  end

  always @(negedge clk) begin
    if (model_rst) begin
      tdrv = 1'b0; bitpos = -1; bidx = 0;
      for (int i = 0; i < 4; i++) begin seen[i] = '0; ack_seen[i] = 1'b0; end
    end else begin
      if (scl_line && prev_scl && prev_sda && !sda_i) begin bitpos = -1; bidx = 0; end
      if (scl_line && prev_scl && !prev_sda && sda_i) begin bitpos = -1; tdrv = 1'b0; end
      if (!prev_scl && scl_line && bitpos >= 0 && bidx < 4) begin
        if (bitpos < 8) seen[bidx] = {seen[bidx][6:0], sda_i};
        else ack_seen[bidx] = sda_i;
      end
      if (prev_scl && !scl_line) begin
        bitpos++;
        if (bitpos == 9) begin bitpos = 0; bidx++; end
        tdrv = (bidx < 4) ? pat[bidx][bitpos] : 1'b0;
      end
    end
    prev_scl = scl_line;
    prev_sda = ~(sda_low | tdrv);
  end

  function automatic logic [8:0] rxpat(input logic [7:0] d);
    logic [8:0] p;
    p[8] = 1'b0;
    for (int i = 0; i < 8; i++) p[i] = ~d[7-i];
    return p;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [5:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wr_buf(input logic [7:0] b);
    @(negedge clk); buf_we = 1'b1; buf_wdata = b;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic wr_clr(input logic [5:0] m);
    @(negedge clk); sts_we = 1'b1; sts_wdata = m;
    @(negedge clk); sts_we = 1'b0;
  endtask

  task automatic wr_ien(input logic [5:0] m);
    @(negedge clk); ien_we = 1'b1; ien_wdata = m;
    @(negedge clk); ien_we = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (cmd_pend != 6'd0 && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) begin
      checks++; fails++;
      $display("FAIL watchdog pending=0x%0h expected=0x0", cmd_pend);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic prep(input logic [8:0] p0, input logic [8:0] p1);
    @(negedge clk); model_rst = 1'b1;
    pat[0] = p0; pat[1] = p1; pat[2] = '0; pat[3] = '0;
    @(negedge clk); model_rst = 1'b0;
  endtask

  typedef struct packed {
    logic [5:0] cmd;
    logic [7:0] txb;
    logic       tack;
    logic       is_rx;
    logic [7:0] rxd;
    logic       nak1;
    logic [5:0] exp_sts;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{6'h23, 8'hA0, 1'b1, 1'b0, 8'h00, 1'b0, 6'h11},  // R2 R3 R6 write, ACKed
    '{6'h23, 8'h42, 1'b0, 1'b0, 8'h00, 1'b0, 6'h12},  // R3 NACKed address, STOP still runs
    '{6'h3B, 8'hA1, 1'b1, 1'b1, 8'h5C, 1'b1, 6'h15},  // R4 R5 read, last byte
    '{6'h2B, 8'hA1, 1'b1, 1'b1, 8'h3A, 1'b0, 6'h15},  // R4 read, ACKed byte
    '{6'h02, 8'h55, 1'b0, 1'b0, 8'h00, 1'b0, 6'h20},  // R8 TX without START
    '{6'h08, 8'h55, 1'b0, 1'b0, 8'h00, 1'b0, 6'h20},  // R8 RX without START
    '{6'h3B, 8'hD3, 1'b1, 1'b1, 8'hC3, 1'b1, 6'h15}   // R4 R5 second data pattern
  };

  initial begin
    #1600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pending", cmd_pend, 0);
    chk("R1 status", status, 0);
    chk("R1 enables", ien, 0);
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_low, sda_low}, 0);

    for (int v = 0; v < NV; v++) begin
      wr_clr(6'h3F);
      prep(TBL[v].tack ? 9'h100 : 9'h000, TBL[v].is_rx ? rxpat(TBL[v].rxd) : 9'h000);
      wr_buf(TBL[v].txb);
      wr_cmd(TBL[v].cmd);
      wait_idle();
      chk("R2 pending cleared", cmd_pend, 0);
      chk("R3 R4 R5 R6 R8 status", status, TBL[v].exp_sts);
      chk("R6 lines released", {scl_low, sda_low}, 0);
      if (TBL[v].cmd[0]) chk("R3 address bits on bus", seen[0], TBL[v].txb);
      if (TBL[v].is_rx) begin
        chk("R4 received byte", buf_rdata[15:8], TBL[v].rxd);
        chk("R5 ninth bit of read", ack_seen[1], TBL[v].nak1);
      end
    end

    // R3 transmit byte reads back in the low half
    wr_buf(8'h9E);
    chk("R3 buffer low byte", buf_rdata[7:0], 8'h9E);

    // R9 write-1-to-clear leaves other flags
    wr_clr(6'h04);
    chk("R9 partial clear", status, 6'h11);
    wr_clr(6'h00);
    chk("R9 zero write no effect", status, 6'h11);

    // R10 interrupt gating
    wr_ien(6'h01);
    chk("R10 irq enabled", irq, 1);
    wr_ien(6'h04);
    chk("R10 irq masked", irq, 0);
    wr_clr(6'h3F);
    wr_ien(6'h3F);
    chk("R10 irq no flags", irq, 0);
    wr_ien(6'h00);

    // R2 START alone self-clears and holds the bus
    prep(9'h000, 9'h000);
    wr_cmd(6'h01);
    wait_idle();
    chk("R2 START cleared", cmd_pend, 0);
    chk("R2 bus held after START", {scl_low, sda_low}, 2'b11);
    chk("R2 no event for START", status, 0);
    wr_cmd(6'h20);
    wait_idle();
    chk("R6 STOP event", status, 6'h10);
    chk("R6 STOP released", {scl_low, sda_low}, 0);

    // R7 arbitration loss on third data bit of 0xFF
    wr_clr(6'h3F);
    prep(9'h004, 9'h000);
    wr_buf(8'hFF);
    wr_cmd(6'h23);
    wait_idle();
    chk("R7 arbitration event", status, 6'h08);
    chk("R7 pending flushed", cmd_pend, 0);
    chk("R7 lines released", {scl_low, sda_low}, 0);
    prep(9'h000, 9'h000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule